// File: doc/BRIEF.md
# Serial-Bus Wiper Position Controller

This block is the digital front end of a 128-step programmable resistor. It acts as a slave on a two-wire serial bus (I2C-compatible) and holds a single 7-bit wiper position. The bus lines are sampled by a faster system clock. An address byte selects the block, and the block answers with an acknowledge. The controller has no register pointer: each write data byte goes straight into the wiper position, and each read data byte returns that position.

The block drives the wiper code continuously to the resistor switch decoder. The bus data line is modelled as an open-drain pull-down enable. The block therefore only ever pulls the line low or lets it go. Clock stretching, general call and 10-bit addressing are not part of this controller.

Top module: `wiper_i2c_slave`

## Requirements
- R1: After reset the wiper code is 0x40 (midscale) and the data-line pull-down is released.
- R2: The first byte after a START holds the 7-bit address in bits 7..1, MSB first, and the direction in bit 0 (0 write, 1 read). When bits 7..1 equal 0101110, the block pulls the data line low during the ninth clock.
- R3: When the address differs, the block gives no acknowledge. Until the next START or STOP it drives nothing and leaves the wiper code untouched.
- R4: In a write, each data byte loads its bits 6..0 into the wiper code and ignores bit 7. The block acknowledges every such byte.
- R5: After one write address byte, every following data byte updates the wiper code again, up to the STOP.
- R6: In a read, each byte the block sends is a 0 bit followed by the wiper code bits 6..0, MSB first. A master acknowledge (data line low in the ninth clock) requests a further byte.
- R7: A master no-acknowledge (data line high in the ninth clock) ends the read. After it the block releases the line and stays silent until the next START or STOP.
- R8: A repeated START at any point returns byte framing to address reception, and the block releases the line.
- R9: START is a falling data line while the clock is high. STOP is a rising data line while the clock is high. A STOP in the middle of a byte loads nothing. When the data line changes in the same system-clock sample as a clock fall, the change counts as an ordinary bit change.
- R10: The block changes its pull-down only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired-AND value) |
| sda_pull | output | 1 | 1 pulls the data line low, 0 releases it |
| wiper_code | output | 7 | Current wiper position to the resistor decoder |

## Verification
Two functions can fall in the same system-clock sample: bus-condition detection (START and STOP) and bit framing on a clock fall. They do so when the master moves the data line at the very instant the clock drops. The bench provokes this by running a whole write with zero hold time after each clock fall. It then expects the written code, not an aborted frame. The checker asserts that at most one bus event is decoded per cycle. It also asserts that the pull-down only moves after a clock fall, START or STOP.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  parameter int CODE_W  = 7;
  parameter int FRAME_W = CODE_W + 1;

  typedef enum logic [2:0] {
    LINK_IDLE,
    LINK_ADDR,
    LINK_WRITE,
    LINK_READ,
    LINK_SKIP
  } link_state_e;

  // Address field sits above the direction bit.
  function automatic logic addr_hit(logic [FRAME_W-1:0] frame, logic [CODE_W-1:0] dev);
    return frame[FRAME_W-1:1] == dev;
  endfunction

  // Outgoing read frame: top bit forced to zero.
  function automatic logic [FRAME_W-1:0] read_frame(logic [CODE_W-1:0] code);
    return {1'b0, code};
  endfunction

  // Write payload: top bit discarded.
  function automatic logic [CODE_W-1:0] payload(logic [FRAME_W-1:0] frame);
    return frame[CODE_W-1:0];
  endfunction

  // Bit sent in slot idx, MSB first.
  function automatic logic frame_bit(logic [FRAME_W-1:0] frame, int unsigned idx);
    return frame[FRAME_W-1-idx];
  endfunction
endpackage

// File: rtl/wiper_line_sync.sv
module wiper_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  output logic line_q,
  output logic line_prev
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain     <= '1;
      line_prev <= 1'b1;
    end else begin
      chain     <= {chain[STAGES-2:0], line_raw};
      line_prev <= chain[STAGES-1];
    end
  end

  assign line_q = chain[STAGES-1];
endmodule

// File: rtl/wiper_store.sv
module wiper_store #(
  parameter int              CODE_W     = 7,
  parameter logic [CODE_W-1:0] RESET_CODE = 7'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [CODE_W-1:0] load_val,
  output logic [CODE_W-1:0] code
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code <= RESET_CODE;
    else if (load_en) code <= load_val;
  end
endmodule

// File: rtl/wiper_link_fsm.sv
module wiper_link_fsm
  import wiper_pkg::*;
#(
  parameter logic [CODE_W-1:0] DEV_ADDR = 7'h2E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_q,
  input  logic              scl_p,
  input  logic              sda_q,
  input  logic              sda_p,
  input  logic [CODE_W-1:0] cur_code,
  output logic              sda_pull,
  output logic              start_evt,
  output logic              stop_evt,
  output logic              scl_rise,
  output logic              scl_fall,
  output logic              wr_load,
  output logic [CODE_W-1:0] load_val,
  output logic              skip_mode
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(FRAME_W + 1);

  link_state_e        state;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] rx;
  logic [FRAME_W-1:0] tx;
  logic               rw;
  logic               nack;
  logic               active;
  logic               byte_done;
  logic               ack_end;
  logic [FRAME_W-1:0] next_tx;

  assign scl_rise  = scl_q & ~scl_p;
  assign scl_fall  = ~scl_q & scl_p;
  assign start_evt = scl_q & scl_p & sda_p & ~sda_q;
  assign stop_evt  = scl_q & scl_p & ~sda_p & sda_q;

  assign active    = (state == LINK_ADDR) || (state == LINK_WRITE) || (state == LINK_READ);
  assign byte_done = active && scl_fall && (bit_cnt == CNT_BYTE);
  assign ack_end   = active && scl_fall && (bit_cnt == CNT_ACK);
  assign wr_load   = byte_done && (state == LINK_WRITE);
  assign load_val  = payload(rx);
  assign skip_mode = (state == LINK_SKIP);
  assign next_tx   = read_frame(cur_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= LINK_IDLE;
      bit_cnt  <= '0;
      rx       <= '0;
      tx       <= '0;
      rw       <= 1'b0;
      nack     <= 1'b0;
      sda_pull <= 1'b0;
    end else if (start_evt) begin
      state    <= LINK_ADDR;
      bit_cnt  <= '0;
      sda_pull <= 1'b0;
    end else if (stop_evt) begin
      state    <= LINK_IDLE;
      bit_cnt  <= '0;
      sda_pull <= 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (bit_cnt < CNT_BYTE) begin
          rx      <= {rx[FRAME_W-2:0], sda_q};
          bit_cnt <= bit_cnt + 1'b1;
        end else if (bit_cnt == CNT_BYTE) begin
          nack    <= sda_q;
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else if (byte_done) begin
        case (state)
          LINK_ADDR: begin
            if (addr_hit(rx, DEV_ADDR)) begin
              sda_pull <= 1'b1;
              rw       <= rx[0];
            end else begin
              state    <= LINK_SKIP;
              sda_pull <= 1'b0;
            end
          end
          LINK_WRITE: sda_pull <= 1'b1;
          default:    sda_pull <= 1'b0;
        endcase
      end else if (ack_end) begin
        bit_cnt <= '0;
        case (state)
          LINK_ADDR: begin
            if (rw) begin
              state    <= LINK_READ;
              tx       <= next_tx;
              sda_pull <= ~frame_bit(next_tx, 0);
            end else begin
              state    <= LINK_WRITE;
              sda_pull <= 1'b0;
            end
          end
          LINK_READ: begin
            if (nack) begin
              state    <= LINK_SKIP;
              sda_pull <= 1'b0;
            end else begin
              tx       <= next_tx;
              sda_pull <= ~frame_bit(next_tx, 0);
            end
          end
          default: sda_pull <= 1'b0;
        endcase
      end else if (scl_fall && state == LINK_READ && bit_cnt != '0) begin
        sda_pull <= ~frame_bit(tx, int'(bit_cnt));
      end
    end
  end
endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave
  import wiper_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] DEV_ADDR    = 7'h2E,
  parameter logic [CODE_W-1:0] RESET_CODE  = CODE_W'(1 << (CODE_W - 1))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull,
  output logic [CODE_W-1:0] wiper_code
);
  localparam int LINES = 2;

  logic [LINES-1:0] line_raw;
  logic [LINES-1:0] line_q;
  logic [LINES-1:0] line_p;
  logic             start_evt;
  logic             stop_evt;
  logic             scl_rise;
  logic             scl_fall;
  logic             wr_load;
  logic [CODE_W-1:0] load_val;
  logic             skip_mode;

  assign line_raw = {sda_in, scl_in};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    wiper_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_raw  (line_raw[g]),
      .line_q    (line_q[g]),
      .line_prev (line_p[g])
    );
  end

  wiper_link_fsm #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_q     (line_q[0]),
    .scl_p     (line_p[0]),
    .sda_q     (line_q[1]),
    .sda_p     (line_p[1]),
    .cur_code  (wiper_code),
    .sda_pull  (sda_pull),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .wr_load   (wr_load),
    .load_val  (load_val),
    .skip_mode (skip_mode)
  );

  wiper_store #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (wr_load),
    .load_val (load_val),
    .code     (wiper_code)
  );
endmodule

// File: rtl/wiper_i2c_checks.sv
module wiper_i2c_checks
  import wiper_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              scl_rise,
  input logic              scl_fall,
  input logic              wr_load,
  input logic [CODE_W-1:0] load_val,
  input logic              skip_mode,
  input logic              sda_pull,
  input logic [CODE_W-1:0] wiper_code
);
  p_events_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_evt, stop_evt, scl_rise, scl_fall}));

  p_start_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_pull);

  p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_pull);

  p_skip_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    skip_mode |-> !sda_pull);

  p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> (wiper_code == $past(load_val)));

  p_hold_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_load |=> $stable(wiper_code));

  p_drive_on_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> ($past(scl_fall) || $past(start_evt) || $past(stop_evt)));
endmodule

bind wiper_i2c_slave wiper_i2c_checks u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_evt  (start_evt),
  .stop_evt   (stop_evt),
  .scl_rise   (scl_rise),
  .scl_fall   (scl_fall),
  .wr_load    (wr_load),
  .load_val   (load_val),
  .skip_mode  (skip_mode),
  .sda_pull   (sda_pull),
  .wiper_code (wiper_code)
);

// File: tb/wiper_i2c_slave_test.sv
module wiper_i2c_slave_test;
  localparam int T = 10;
  localparam int NVEC = 7;
  // {addr[24:18], rw[17], ack[16], data[15:8], expected[7:0]}
  localparam logic [24:0] VEC [NVEC] = '{
    {7'h2E, 1'b0, 1'b1, 8'h15, 8'h15},
    {7'h2E, 1'b0, 1'b1, 8'hFF, 8'h7F},
    {7'h2F, 1'b0, 1'b0, 8'h00, 8'h7F},
    {7'h2E, 1'b1, 1'b1, 8'h00, 8'h7F},
    {7'h2E, 1'b0, 1'b1, 8'h80, 8'h00},
    {7'h6E, 1'b1, 1'b0, 8'h00, 8'hFF},
    {7'h2E, 1'b1, 1'b1, 8'h00, 8'h00}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_bus;
  logic       sda_pull;
  logic [6:0] wiper_code;
  int         checks = 0;
  int         errors = 0;
  int         hold = 2;
  int         viol = 0;
  logic       scl_d = 1'b1;
  logic       pull_d = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;

  wiper_i2c_slave uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_m),
    .sda_in     (sda_bus),
    .sda_pull   (sda_pull),
    .wiper_code (wiper_code)
  );

  // R10 monitor: pull-down must not move while the bus clock stays high
  always @(negedge clk) begin
    if (rst_n && scl_m && scl_d && (sda_pull !== pull_d)) viol <= viol + 1;
    scl_d  <= scl_m;
    pull_d <= sda_pull;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sda_m = b;
    wait_clk(T);
    scl_m = 1'b1;
    wait_clk(T);
    scl_m = 1'b0;
    wait_clk(hold);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1;
    wait_clk(T);
    scl_m = 1'b1;
    wait_clk(T / 2);
    ack = ~sda_bus;
    wait_clk(T / 2);
    scl_m = 1'b0;
    wait_clk(hold);
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1;
      wait_clk(T);
      scl_m = 1'b1;
      wait_clk(T / 2);
      b[i] = sda_bus;
      wait_clk(T / 2);
      scl_m = 1'b0;
      wait_clk(hold);
    end
    send_bit(~master_ack);
  endtask

  task automatic do_start();
    if (!scl_m) begin
      sda_m = 1'b1;
      wait_clk(T);
      scl_m = 1'b1;
      wait_clk(T);
    end
    sda_m = 1'b0;
    wait_clk(T);
    scl_m = 1'b0;
    wait_clk(hold);
  endtask

  task automatic do_stop();
    sda_m = 1'b0;
    wait_clk(T);
    scl_m = 1'b1;
    wait_clk(T);
    sda_m = 1'b1;
    wait_clk(T);
  endtask

  initial begin
    wait_clk(150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic       ack;
    logic [7:0] rd;
    wait_clk(5);
    // R1: reset state
    check8("R1 reset code", {1'b0, wiper_code}, 8'h40);
    check8("R1 reset pull", {7'd0, sda_pull}, 8'h00);
    rst_n = 1'b1;
    wait_clk(5);
    check8("R1 code after reset release", {1'b0, wiper_code}, 8'h40);

    // Vector table: R2 address/ack, R3 mismatch, R4 write, R6 read
    for (int v = 0; v < NVEC; v++) begin
      do_start();
      send_byte({VEC[v][24:18], VEC[v][17]}, ack);
      check8($sformatf("R2/R3 address ack vec %0d", v), {7'd0, ack}, {7'd0, VEC[v][16]});
      if (!VEC[v][17]) begin
        send_byte(VEC[v][15:8], ack);
        do_stop();
        check8($sformatf("R4/R3 wiper after write vec %0d", v), {1'b0, wiper_code}, VEC[v][7:0]);
      end else begin
        recv_byte(1'b0, rd);
        do_stop();
        check8($sformatf("R6/R3 read byte vec %0d", v), rd, VEC[v][7:0]);
      end
    end

    // R5: multi-byte write updates after every byte
    do_start();
    send_byte({7'h2E, 1'b0}, ack);
    send_byte(8'h11, ack);
    check8("R5 first byte", {1'b0, wiper_code}, 8'h11);
    check8("R4 data ack", {7'd0, ack}, 8'h01);
    send_byte(8'hA2, ack);
    check8("R5 second byte", {1'b0, wiper_code}, 8'h22);
    send_byte(8'h33, ack);
    check8("R5 third byte", {1'b0, wiper_code}, 8'h33);
    do_stop();

    // R6/R7: repeated read, NACK, then silence
    do_start();
    send_byte({7'h2E, 1'b1}, ack);
    recv_byte(1'b1, rd);
    check8("R6 read byte one", rd, 8'h33);
    recv_byte(1'b0, rd);
    check8("R6 read byte two", rd, 8'h33);
    recv_byte(1'b0, rd);
    check8("R7 silent after nack", rd, 8'hFF);
    do_stop();

    // R9: STOP in mid-byte loads nothing
    do_start();
    send_byte({7'h2E, 1'b0}, ack);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    do_stop();
    check8("R9 stop mid-byte", {1'b0, wiper_code}, 8'h33);

    // R8: repeated START mid-byte restarts address framing
    do_start();
    send_byte({7'h2E, 1'b0}, ack);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    do_start();
    send_byte({7'h2E, 1'b1}, ack);
    check8("R8 ack after repeated start", {7'd0, ack}, 8'h01);
    recv_byte(1'b0, rd);
    check8("R8 read after repeated start", rd, 8'h33);
    do_stop();

    // R9: data moves in the same sample as the clock fall
    hold = 0;
    do_start();
    send_byte({7'h2E, 1'b0}, ack);
    send_byte(8'h5A, ack);
    do_stop();
    hold = 2;
    wait_clk(T);
    check8("R9 zero-hold write", {1'b0, wiper_code}, 8'h5A);

    // R10: pull-down never moved during a high clock
    check8("R10 drive only while clock low", 8'(viol), 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule